// File: doc/BRIEF.md
# Double-Precision Square Root with Data-Dependent Early-Out

This unit takes one IEEE 754 binary64 operand through a valid/ready start handshake and returns its square root, rounded to nearest-even, together with an invalid flag and an inexact flag. Only one operation is in flight at a time. The unit accepts no new start until the result of the current operation has been delivered on the single-cycle done strobe.

Every operand is sorted into one of two latency classes when it is accepted. Special operands finish in a short, fixed number of cycles. These are zeros, infinities, NaNs and negative nonzero values. Positive normal values whose fraction is all zero and whose unbiased exponent is even also finish in that time, because their roots are exact powers of two. All other operands take a longer fixed latency. In that time a digit recurrence extracts several root bits per cycle from a normalized radicand. Subnormal operands are normalized with a leading-zero count. Because both latencies are constants, a scheduler can predict when each result will arrive from the class of its operand alone.

Top module: `dsqrt_early`

## Requirements
- R1: `in_ready` is low while reset is applied or an operation is in flight, and high otherwise. A start is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` returns high in the cycle after `out_done`.
- R2: For fast-class operands, `out_done` is high in the cycle sampled by the 13th rising edge after the accepting edge, and is low in every other cycle. Fast-class operands are ±0, ±infinity, any NaN, any negative nonzero value, and any positive normal value with an all-zero fraction and an even unbiased exponent.
- R3: For all other operands, `out_done` is high only in the cycle sampled by the 18th rising edge after the accepting edge. This includes subnormals, zero-fraction values with an odd unbiased exponent, and any value with a nonzero fraction.
- R4: A positive normal value with a zero fraction and even unbiased exponent E returns sign 0, biased exponent E/2+1023, a zero fraction, and both flags clear.
- R5: A positive normal slow-class operand returns its square root correctly rounded to nearest, ties to even. The result is always a positive normal number.
- R6: `out_inexact` is 1 exactly when the rounded result differs from the true root. It is always 0 for fast-class operands.
- R7: +0 returns +0 (0x0000000000000000) and -0 returns -0 (0x8000000000000000), with both flags clear.
- R8: +infinity (0x7FF0000000000000) returns +infinity with both flags clear.
- R9: Any negative nonzero, non-NaN operand, including -infinity and negative subnormals, returns the quiet NaN 0x7FF8000000000000 with `out_invalid` set.
- R10: A NaN operand (exponent field all ones, fraction nonzero) returns the operand with fraction bit 51 forced to 1, keeping its sign and payload. `out_invalid` is set only if bit 51 of the operand was 0 (signaling).
- R11: A positive subnormal operand is normalized before the recurrence and returns its correctly rounded root, which is always a normal number.
- R12: `in_valid` and `in_op` have no effect while an operation is in flight. The delivered result belongs to the accepted operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| in_valid | input | 1 | Start request |
| in_ready | output | 1 | Unit can take a start this cycle |
| in_op | input | 64 | Binary64 operand, sampled when the start is taken |
| out_done | output | 1 | One-cycle strobe, result and flags valid |
| out_res | output | 64 | Binary64 root, zero when `out_done` is low |
| out_invalid | output | 1 | Invalid-operation flag, qualified by `out_done` |
| out_inexact | output | 1 | Inexact flag, qualified by `out_done` |

## Verification
The bench drives exact powers of four such as 0.25, 1, 4 and 16 to separate the exponent-only fast path from the recurrence. It drives 2.0, 9.0 and 2.25 to confirm that an odd exponent or any set fraction bit forces the long latency, whether or not the root is exact. Zeros of both signs, infinities, quiet and signaling NaNs and negative values check the special-case encodings and the invalid flag. Subnormals, including the smallest one and a subnormal power of two, exercise normalization. A stream of pseudo-random positive normals checks rounding and the inexact flag against an exact integer squaring test, while junk operands are offered during every busy period.

// File: rtl/dsqrt_pkg.sv
package dsqrt_pkg;
  localparam int FP_W     = 64;
  localparam int EXP_W    = 11;
  localparam int FRAC_W   = 52;
  localparam int EXP_BIAS = 1023;

  localparam logic [FP_W-1:0] CANON_QNAN = 64'h7FF8_0000_0000_0000;

  // Result source chosen at accept time
  typedef enum logic [1:0] {
    P_SPECIAL = 2'd0,   // value fixed at accept (zero, inf, NaN, negative)
    P_POW4    = 2'd1,   // exponent halving only
    P_ROOT    = 2'd2    // digit recurrence plus rounding
  } path_e;
endpackage

// File: rtl/dsqrt_classify.sv
module dsqrt_classify
  import dsqrt_pkg::*;
#(
  parameter int ROOT_BITS = 56
) (
  input  logic [FP_W-1:0]        op_i,
  output path_e                  path_o,
  output logic [FP_W-1:0]        spec_o,
  output logic                   inv_o,
  output logic [2*ROOT_BITS-1:0] rad_o,
  output logic [EXP_W-1:0]       rexp_o
);
  localparam int PAD = 2*ROOT_BITS - (FRAC_W + 2);

  logic              sgn;
  logic [EXP_W-1:0]  ex;
  logic [FRAC_W-1:0] fr;
  logic [5:0]        lz;
  logic signed [12:0] e_unb, e_even;
  logic [FRAC_W:0]   mant;
  logic [FRAC_W+1:0] mant2;
  logic              odd;
  logic              is_nan, is_inf, is_zero;

  assign sgn = op_i[FP_W-1];
  assign ex  = op_i[FP_W-2 -: EXP_W];
  assign fr  = op_i[FRAC_W-1:0];

  // leading-zero count of the fraction (only meaningful for subnormals)
  always_comb begin
    lz = 6'(FRAC_W);
    for (int i = 0; i < FRAC_W; i++) begin
      if (fr[i]) lz = 6'(FRAC_W - 1 - i);
    end
  end

  // normalized significand and unbiased exponent; odd exponent folds into the significand
  always_comb begin
    if (ex == '0) begin
      e_unb = -13'sd1023 - $signed({7'b0, lz});
      mant  = (53'(fr)) << (lz + 6'd1);
    end else begin
      e_unb = $signed({2'b0, ex}) - 13'sd1023;
      mant  = {1'b1, fr};
    end
    odd    = e_unb[0];
    mant2  = odd ? {mant, 1'b0} : {1'b0, mant};
    e_even = e_unb - $signed({12'b0, odd});
    rexp_o = EXP_W'((e_even >>> 1) + 13'sd1023);
    rad_o  = {mant2, {PAD{1'b0}}};
  end

  assign is_nan  = (&ex) & (|fr);
  assign is_inf  = (&ex) & ~(|fr);
  assign is_zero = ~(|ex) & ~(|fr);

  // special-case priority: NaN, zero, negative, infinity, power of four
  always_comb begin
    path_o = P_ROOT;
    spec_o = op_i;
    inv_o  = 1'b0;
    if (is_nan) begin
      path_o = P_SPECIAL;
      spec_o = {op_i[FP_W-1:FRAC_W], 1'b1, op_i[FRAC_W-2:0]};
      inv_o  = ~fr[FRAC_W-1];
    end else if (is_zero) begin
      path_o = P_SPECIAL;
    end else if (sgn) begin
      path_o = P_SPECIAL;
      spec_o = CANON_QNAN;
      inv_o  = 1'b1;
    end else if (is_inf) begin
      path_o = P_SPECIAL;
    end else if ((ex != '0) && (fr == '0) && !odd) begin
      path_o = P_POW4;
    end
  end
endmodule

// File: rtl/dsqrt_digit_stage.sv
module dsqrt_digit_stage #(
  parameter int ROOT_BITS = 56,
  parameter int REM_W     = ROOT_BITS + 4
) (
  input  logic [REM_W-1:0]       rem_i,
  input  logic [ROOT_BITS-1:0]   q_i,
  input  logic [2*ROOT_BITS-1:0] rad_i,
  output logic [REM_W-1:0]       rem_o,
  output logic [ROOT_BITS-1:0]   q_o,
  output logic [2*ROOT_BITS-1:0] rad_o
);
  logic [REM_W+1:0] cand, trial;
  logic             ge;

  // restoring step: bring down two radicand bits, try root*4+1
  always_comb begin
    cand  = {rem_i, rad_i[2*ROOT_BITS-1 -: 2]};
    trial = {{(REM_W-ROOT_BITS){1'b0}}, q_i, 2'b01};
    ge    = (cand >= trial);
    rem_o = REM_W'(ge ? (cand - trial) : cand);
    q_o   = {q_i[ROOT_BITS-2:0], ge};
    rad_o = {rad_i[2*ROOT_BITS-3:0], 2'b00};
  end
endmodule

// File: rtl/dsqrt_round.sv
module dsqrt_round
  import dsqrt_pkg::*;
#(
  parameter int ROOT_BITS = 56
) (
  input  logic [ROOT_BITS-1:0] q_i,
  input  logic                 rem_nz_i,
  input  logic [EXP_W-1:0]     exp_i,
  output logic [FP_W-1:0]      res_o,
  output logic                 inexact_o
);
  localparam int GPOS = ROOT_BITS - FRAC_W - 2;

  logic              guard, sticky, up;
  logic [FRAC_W:0]   fsum;
  logic              carry;

  always_comb begin
    guard     = q_i[GPOS];
    sticky    = (|q_i[GPOS-1:0]) | rem_nz_i;
    up        = guard & (sticky | q_i[GPOS+1]);
    fsum      = {1'b0, q_i[GPOS+FRAC_W:GPOS+1]} + {{FRAC_W{1'b0}}, up};
    carry     = fsum[FRAC_W] & q_i[ROOT_BITS-1];
    res_o     = {1'b0, exp_i + {{(EXP_W-1){1'b0}}, carry}, fsum[FRAC_W-1:0]};
    inexact_o = guard | sticky;
  end
endmodule

// File: rtl/dsqrt_early.sv
module dsqrt_early
  import dsqrt_pkg::*;
#(
  parameter int ROOT_BITS      = 56,
  parameter int BITS_PER_CYCLE = 4,
  parameter int LAT_FAST       = 13,
  parameter int LAT_SLOW       = 18
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [FP_W-1:0] in_op,
  output logic            out_done,
  output logic [FP_W-1:0] out_res,
  output logic            out_invalid,
  output logic            out_inexact
);
  localparam int ITER  = ROOT_BITS / BITS_PER_CYCLE;
  localparam int REM_W = ROOT_BITS + 4;
  localparam int RAD_W = 2 * ROOT_BITS;
  localparam int CW    = $clog2(LAT_SLOW + 1);
  localparam int IW    = $clog2(ITER + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       arst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign arst_n = rsync_q[1];

  // state
  logic               busy_q, busy_d;
  logic               fast_q;
  logic [CW-1:0]      cnt_q, cnt_d;
  path_e              path_q;
  logic [FP_W-1:0]    spec_q;
  logic               inv_q;
  logic [EXP_W-1:0]   exp_q;
  logic [RAD_W-1:0]   rad_q;
  logic [REM_W-1:0]   rem_q;
  logic [ROOT_BITS-1:0] q_q;
  logic [IW-1:0]      it_q;

  // classification of the incoming operand
  path_e              c_path;
  logic [FP_W-1:0]    c_spec;
  logic               c_inv;
  logic [RAD_W-1:0]   c_rad;
  logic [EXP_W-1:0]   c_exp;

  dsqrt_classify #(.ROOT_BITS(ROOT_BITS)) u_classify (
    .op_i  (in_op),
    .path_o(c_path),
    .spec_o(c_spec),
    .inv_o (c_inv),
    .rad_o (c_rad),
    .rexp_o(c_exp)
  );

  // recurrence: BITS_PER_CYCLE digit stages chained per cycle
  logic [REM_W-1:0]     rem_c [BITS_PER_CYCLE+1];
  logic [ROOT_BITS-1:0] q_c   [BITS_PER_CYCLE+1];
  logic [RAD_W-1:0]     rad_c [BITS_PER_CYCLE+1];

  assign rem_c[0] = rem_q;
  assign q_c[0]   = q_q;
  assign rad_c[0] = rad_q;

  for (genvar g = 0; g < BITS_PER_CYCLE; g++) begin : g_stage
    dsqrt_digit_stage #(.ROOT_BITS(ROOT_BITS), .REM_W(REM_W)) u_stage (
      .rem_i(rem_c[g]),
      .q_i  (q_c[g]),
      .rad_i(rad_c[g]),
      .rem_o(rem_c[g+1]),
      .q_o  (q_c[g+1]),
      .rad_o(rad_c[g+1])
    );
  end

  logic [FP_W-1:0] rnd_res;
  logic            rnd_inexact;

  dsqrt_round #(.ROOT_BITS(ROOT_BITS)) u_round (
    .q_i      (q_q),
    .rem_nz_i (|rem_q),
    .exp_i    (exp_q),
    .res_o    (rnd_res),
    .inexact_o(rnd_inexact)
  );

  // next-state
  logic accept, lat_hit, step_en;

  always_comb begin
    in_ready = arst_n & ~busy_q;
    accept   = in_valid & in_ready;
    lat_hit  = (cnt_q == (fast_q ? CW'(LAT_FAST) : CW'(LAT_SLOW)));
    out_done = busy_q & lat_hit;
    step_en  = busy_q & (path_q == P_ROOT) & (it_q != IW'(ITER));
    busy_d   = accept ? 1'b1 : (out_done ? 1'b0 : busy_q);
    cnt_d    = accept ? CW'(1) : (busy_q ? cnt_q + CW'(1) : cnt_q);
  end

  // registers
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      fast_q <= 1'b0;
      path_q <= P_SPECIAL;
      spec_q <= '0;
      inv_q  <= 1'b0;
      exp_q  <= '0;
      rad_q  <= '0;
      rem_q  <= '0;
      q_q    <= '0;
      it_q   <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      if (accept) begin
        fast_q <= (c_path != P_ROOT);
        path_q <= c_path;
        spec_q <= c_spec;
        inv_q  <= c_inv;
        exp_q  <= c_exp;
        rad_q  <= c_rad;
        rem_q  <= '0;
        q_q    <= '0;
        it_q   <= '0;
      end else if (step_en) begin
        rad_q  <= rad_c[BITS_PER_CYCLE];
        rem_q  <= rem_c[BITS_PER_CYCLE];
        q_q    <= q_c[BITS_PER_CYCLE];
        it_q   <= it_q + IW'(1);
      end
    end
  end

  // outputs, qualified by the done strobe
  always_comb begin
    out_res     = '0;
    out_invalid = 1'b0;
    out_inexact = 1'b0;
    if (out_done) begin
      unique case (path_q)
        P_ROOT:  out_res = rnd_res;
        P_POW4:  out_res = {1'b0, exp_q, {FRAC_W{1'b0}}};
        default: out_res = spec_q;
      endcase
      out_invalid = inv_q;
      out_inexact = (path_q == P_ROOT) & rnd_inexact;
    end
  end

  // assertions
  a_r1_accept_needs_valid: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(busy_q) |-> $past(in_valid));

  a_r1_ready_after_done: assert property (@(posedge clk) disable iff (!arst_n)
    out_done |=> in_ready);

  a_r3_root_iterations_done: assert property (@(posedge clk) disable iff (!arst_n)
    (out_done && path_q == P_ROOT) |-> (it_q == IW'(ITER)));

  a_r9_invalid_is_nan: assert property (@(posedge clk) disable iff (!arst_n)
    (out_done && out_invalid) |-> ((&out_res[62:52]) && out_res[51]));

  a_r5_root_exp_normal: assert property (@(posedge clk) disable iff (!arst_n)
    (out_done && path_q == P_ROOT) |->
      (!out_res[63] && (out_res[62:52] != '0) && !(&out_res[62:52])));

  a_r12_operand_held: assert property (@(posedge clk) disable iff (!arst_n)
    (busy_q && $past(busy_q)) |-> ($stable(exp_q) && $stable(path_q) && $stable(spec_q)));
endmodule

// File: tb/dsqrt_early_bench.sv
`timescale 1ns/1ps
module dsqrt_early_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [63:0] in_op;
  logic        out_done;
  logic [63:0] out_res;
  logic        out_invalid;
  logic        out_inexact;

  always #2.5 clk = ~clk;

  dsqrt_early u_dsqrt_early (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .out_done(out_done), .out_res(out_res),
    .out_invalid(out_invalid), .out_inexact(out_inexact)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // split a binary64 into integer significand and power of two
  function automatic void split(input logic [63:0] b, output logic [52:0] m, output int ex);
    if (b[62:52] == 0) begin m = {1'b0, b[51:0]}; ex = -1074; end
    else begin m = {1'b1, b[51:0]}; ex = int'(b[62:52]) - 1075; end
  endfunction

  // exact test: r*r == x in integers
  function automatic bit square_exact(input logic [63:0] rb, input logic [63:0] xb);
    logic [52:0] mr, mx;
    int er, ex, d;
    logic [191:0] a, b;
    split(rb, mr, er);
    split(xb, mx, ex);
    a = 192'(mr) * 192'(mr);
    b = 192'(mx);
    d = 2*er - ex;
    if (d >= 0) begin
      if (d > 80) return 1'b0;
      a = a << d;
    end else begin
      if (-d > 130) return 1'b0;
      b = b << (-d);
    end
    return a == b;
  endfunction

  function automatic void ref_sqrt(input logic [63:0] op, output logic [63:0] res,
                                   output bit inv, output bit inx, output int lat,
                                   output string tag);
    logic [10:0] e = op[62:52];
    logic [51:0] f = op[51:0];
    real r;
    inv = 0; inx = 0; lat = 13;
    if (e == 11'h7FF && f != 0) begin
      res = op | 64'h0008_0000_0000_0000; inv = !f[51]; tag = "R10";
    end else if (e == 0 && f == 0) begin
      res = op; tag = "R7";
    end else if (op[63]) begin
      res = 64'h7FF8_0000_0000_0000; inv = 1; tag = "R9";
    end else if (e == 11'h7FF) begin
      res = op; tag = "R8";
    end else begin
      r   = $sqrt($bitstoreal(op));
      res = $realtobits(r);
      if (e != 0 && f == 0 && e[0]) begin
        tag = "R4";
      end else begin
        lat = 18;
        tag = (e == 0) ? "R11" : "R5";
        inx = !square_exact(res, op);
      end
    end
  endfunction

  logic [63:0] ops[$];

  initial begin
    logic [63:0] s;
    bit          m_busy;
    int          m_edges, m_lat;
    logic [63:0] e_res;
    bit          e_inv, e_inx;
    string       e_tag;
    bit          pv_valid, pv_ready;
    logic [63:0] pv_op;
    int          cyc;
    bit          exp_done;

    // directed operands
    ops.push_back(64'h3FD0_0000_0000_0000); // 0.25  fast
    ops.push_back(64'h3FF0_0000_0000_0000); // 1.0   fast
    ops.push_back(64'h4010_0000_0000_0000); // 4.0   fast
    ops.push_back(64'h4030_0000_0000_0000); // 16.0  fast
    ops.push_back(64'h4000_0000_0000_0000); // 2.0   slow, odd exponent
    ops.push_back(64'h4022_0000_0000_0000); // 9.0   slow, exact
    ops.push_back(64'h4002_0000_0000_0000); // 2.25  slow, exact
    ops.push_back(64'h4008_0000_0000_0000); // 3.0
    ops.push_back(64'h3FC3_3333_3333_3333); // 0.15
    ops.push_back(64'h0000_0000_0000_0000); // +0
    ops.push_back(64'h8000_0000_0000_0000); // -0
    ops.push_back(64'h7FF0_0000_0000_0000); // +inf
    ops.push_back(64'hFFF0_0000_0000_0000); // -inf
    ops.push_back(64'h7FF8_0000_0000_0123); // quiet NaN
    ops.push_back(64'h7FF0_0000_0000_0001); // signaling NaN
    ops.push_back(64'hFFF4_0000_0000_00AB); // negative signaling NaN
    ops.push_back(64'hC010_0000_0000_0000); // -4.0
    ops.push_back(64'h8000_0000_0000_0001); // negative subnormal
    ops.push_back(64'h0000_0000_0000_0001); // smallest subnormal
    ops.push_back(64'h0000_0000_0000_0004); // subnormal power of two
    ops.push_back(64'h000F_FFFF_FFFF_FFFF); // largest subnormal
    ops.push_back(64'h0010_0000_0000_0000); // smallest normal
    ops.push_back(64'h7FEF_FFFF_FFFF_FFFF); // largest finite
    ops.push_back(64'h3FEF_FFFF_FFFF_FFFF); // just below one
    s = 64'h9E37_79B9_7F4A_7C15;
    for (int k = 0; k < 40; k++) begin
      s = s ^ (s << 13); s = s ^ (s >> 7); s = s ^ (s << 17);
      ops.push_back({1'b0, 11'(1 + int'(s[40:30]) % 2046), s[51:0]});
    end

    rst_n = 1'b0; in_valid = 1'b0; in_op = '0;
    repeat (3) @(negedge clk);
    check("R1 ready in reset", {63'b0, in_ready}, 64'd0);
    check("R1 done in reset",  {63'b0, out_done}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 ready after reset", {63'b0, in_ready}, 64'd1);

    m_busy = 0; m_edges = 0; m_lat = 13;
    e_res = '0; e_inv = 0; e_inx = 0; e_tag = "";
    pv_valid = 0; pv_ready = in_ready; pv_op = '0;
    cyc = 0;

    while ((ops.size() > 0 || m_busy || pv_valid) && cyc < 100000) begin
      @(negedge clk);
      cyc++;
      // model the edge that just passed
      if (m_busy) begin
        m_edges++;
        if (m_edges == m_lat) m_busy = 0;
      end else if (pv_valid && pv_ready) begin
        m_busy = 1; m_edges = 0;
        ref_sqrt(pv_op, e_res, e_inv, e_inx, m_lat, e_tag);
        void'(ops.pop_front());
      end
      // compare every cycle
      exp_done = m_busy && (m_edges == m_lat - 1);
      check("R1/R12 in_ready", {63'b0, in_ready}, {63'b0, !m_busy});
      check(m_lat == 13 ? "R2 done timing" : "R3 done timing",
            {63'b0, out_done}, {63'b0, exp_done});
      if (exp_done && out_done) begin
        check({e_tag, " result"}, out_res, e_res);
        check({e_tag, " invalid"}, {63'b0, out_invalid}, {63'b0, e_inv});
        check("R6 inexact", {63'b0, out_inexact}, {63'b0, e_inx});
      end
      // drive: junk while busy must be ignored (R12)
      if (ops.size() > 0) begin
        if (m_busy) begin
          in_valid = 1'b1;
          in_op    = 64'hBFF0_0000_0000_0000 ^ 64'(cyc);
        end else begin
          in_valid = (cyc % 7) != 3;
          in_op    = ops[0];
        end
      end else begin
        in_valid = 1'b0;
        in_op    = '0;
      end
      pv_valid = in_valid;
      pv_op    = in_op;
      pv_ready = in_ready;
    end

    if (cyc >= 100000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not finish, got %0d cycles expected fewer", cyc);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule